// File: doc/BRIEF.md
# One-Hot State Holder with Binary Parity Shadow

This block holds the present state of a one-hot encoded state machine and protects it against a single flipped storage bit. Beside the one-hot register it keeps a compact shadow: the binary index of the same state plus one even-parity bit over that index. All three copies load on the same clock edge. The next-state and output logic of the machine live outside. The next-state logic feeds the block a one-hot next state and a load enable. It reads back the repaired one-hot present state.

The parity check decides which copy to believe. One upset can corrupt either the one-hot copy or the index-plus-parity copy, but never both. A parity mismatch therefore means the one-hot register is intact, and it is passed through. When parity agrees, the index is decoded back to one-hot and used. The hold path recirculates the repaired state rather than the raw register. Any upset is therefore scrubbed at the next edge, whether or not a load happens. A fault-injection input XORs a mask into the register inputs so that stored-bit flips can be produced deliberately.

Top module: `ohp_state_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `state_o` equal to the one-hot word with only bit RESET_IDX set, and `upset_o` low.
- R2: With `load_en` high at an edge, `state_o` in the following cycle equals the one-hot `next_i` sampled at that edge. This holds even if a single bit is injected on that same edge.
- R3: With `load_en` low at an edge, `state_o` in the following cycle equals its value before the edge. This holds even if a single bit is injected on that same edge.
- R4: A flip in one-hot bit i is injected through `inj_i[i]` (bits 0 to N_STATES-1). It is corrected from the stored binary index and does not change `state_o`.
- R5: A flip in binary index bit b (`inj_i[N_STATES+b]`) is corrected by passing the one-hot register through. So is a flip in the parity bit (`inj_i[N_STATES+IDX_W]`, the top bit of `inj_i`).
- R6: `upset_o` is high in exactly the cycle after an edge at which a nonzero single-bit `inj_i` was stored, and low in every other cycle.
- R7: The edge following an upset rewrites all three copies consistently, with or without `load_en`. A single flip in a different copy on that edge is therefore corrected as well.
- R8: `state_o` has exactly one bit set in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load `next_i` at this edge when high; hold the repaired state when low |
| next_i | input | N_STATES | One-hot next state |
| inj_i | input | N_STATES+IDX_W+1 | Fault mask XORed into the register inputs: one-hot bits, then index bits, then parity on top |
| state_o | output | N_STATES | Corrected one-hot present state |
| upset_o | output | 1 | High while a stored copy disagrees with the others |

## Verification
The hardest situation is two upsets on consecutive edges that land in different copies. An example is a one-hot flip followed at once by an index flip while the enable is low. This situation only stays correct if the scrub on the first repair edge worked. The stimulus uses the injection mask to place single flips into each region in turn. Directed back-to-back sequences cover both orders. Random cycles then mix single flips with random loads and holds.

// File: rtl/ohp_pkg.sv
package ohp_pkg;
  function automatic int idx_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ohp_encode.sv
module ohp_encode #(
  parameter int N_STATES = 6,
  parameter int IDX_W    = 3
) (
  input  logic [N_STATES-1:0] onehot_i,
  output logic [IDX_W-1:0]    index_o,
  output logic                parity_o
);
  always_comb begin
    index_o = '0;
    for (int i = 0; i < N_STATES; i++) begin
      if (onehot_i[i]) index_o = index_o | IDX_W'(i);
    end
  end

  assign parity_o = ^index_o;
endmodule

// File: rtl/ohp_correct.sv
module ohp_correct #(
  parameter int N_STATES = 6,
  parameter int IDX_W    = 3
) (
  input  logic [N_STATES-1:0] oh_q,
  input  logic [IDX_W-1:0]    idx_q,
  input  logic                par_q,
  output logic [N_STATES-1:0] fixed_o,
  output logic                upset_o
);
  logic [N_STATES-1:0] decoded;
  logic                par_bad;

  for (genvar i = 0; i < N_STATES; i++) begin : g_dec
    assign decoded[i] = (idx_q == IDX_W'(i));
  end

  assign par_bad = (^idx_q) ^ par_q;
  assign fixed_o = par_bad ? oh_q : decoded;
  assign upset_o = par_bad | (oh_q != decoded);
endmodule

// File: rtl/ohp_state_reg.sv
module ohp_state_reg #(
  parameter int N_STATES  = 6,
  parameter int RESET_IDX = 0,
  localparam int IDX_W    = ohp_pkg::idx_width(N_STATES),
  localparam int INJ_W    = N_STATES + IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic [N_STATES-1:0] next_i,
  input  logic [INJ_W-1:0]    inj_i,
  output logic [N_STATES-1:0] state_o,
  output logic                upset_o
);
  localparam logic [N_STATES-1:0] RST_OH  = N_STATES'(1) << RESET_IDX;
  localparam logic [IDX_W-1:0]    RST_IDX = IDX_W'(RESET_IDX);
  localparam logic                RST_PAR = ^RST_IDX;

  logic [N_STATES-1:0] oh_q, fixed, sel;
  logic [IDX_W-1:0]    idx_q, sel_idx;
  logic                par_q, sel_par;

  ohp_correct #(.N_STATES(N_STATES), .IDX_W(IDX_W)) u_correct (
    .oh_q(oh_q), .idx_q(idx_q), .par_q(par_q),
    .fixed_o(fixed), .upset_o(upset_o)
  );

  assign sel = load_en ? next_i : fixed;

  ohp_encode #(.N_STATES(N_STATES), .IDX_W(IDX_W)) u_encode (
    .onehot_i(sel), .index_o(sel_idx), .parity_o(sel_par)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oh_q  <= RST_OH;
      idx_q <= RST_IDX;
      par_q <= RST_PAR;
    end else begin
      oh_q  <= sel     ^ inj_i[N_STATES-1:0];
      idx_q <= sel_idx ^ inj_i[N_STATES +: IDX_W];
      par_q <= sel_par ^ inj_i[INJ_W-1];
    end
  end

  assign state_o = fixed;
endmodule

// File: rtl/ohp_state_reg_chk.sv
module ohp_state_reg_chk #(
  parameter int N_STATES  = 6,
  parameter int RESET_IDX = 0,
  parameter int INJ_W     = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                load_en,
  input logic [N_STATES-1:0] next_i,
  input logic [INJ_W-1:0]    inj_i,
  input logic [N_STATES-1:0] state_o,
  input logic                upset_o
);
  localparam logic [N_STATES-1:0] RST_OH = N_STATES'(1) << RESET_IDX;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (state_o == RST_OH && !upset_o)); // R1

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (load_en && $countones(next_i) == 1 && $countones(inj_i) <= 1)
      |=> state_o == $past(next_i)); // R2

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!load_en && $countones(inj_i) <= 1) |=> $stable(state_o)); // R3

  AST_NO_FLIP_NO_UPSET: assert property (@(posedge clk) disable iff (rst)
    (inj_i == '0) |=> !upset_o); // R6

  AST_FLIP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    ($countones(inj_i) == 1) |=> upset_o); // R6

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $countones(state_o) == 1); // R8
endmodule

bind ohp_state_reg ohp_state_reg_chk #(
  .N_STATES(N_STATES), .RESET_IDX(RESET_IDX), .INJ_W(INJ_W)
) u_chk (
  .clk(clk), .rst(rst), .load_en(load_en), .next_i(next_i),
  .inj_i(inj_i), .state_o(state_o), .upset_o(upset_o)
);

// File: tb/ohp_state_reg_test.sv
module ohp_state_reg_test;
  localparam int N  = 6;
  localparam int RI = 0;
  localparam int BW = 3;
  localparam int IW = N + BW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [N-1:0]  next_i = '0;
  logic [IW-1:0] inj_i = '0;
  logic [N-1:0]  state_o;
  logic          upset_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] exp_state;
  logic         exp_upset;
  logic         done = 1'b0;

  ohp_state_reg #(.N_STATES(N), .RESET_IDX(RI)) uut (
    .clk(clk), .rst(rst), .load_en(load_en), .next_i(next_i),
    .inj_i(inj_i), .state_o(state_o), .upset_o(upset_o)
  );

  always #2 clk = ~clk;

  function automatic logic [N-1:0] oh(input int k);
    return N'(1) << k;
  endfunction

  function automatic logic [IW-1:0] flip(input int k);
    return IW'(1) << k;
  endfunction

  task automatic chk(input string req);
    checks++;
    if (state_o !== exp_state || upset_o !== exp_upset) begin
      errors++;
      $display("FAIL %s state=%b upset=%b expected state=%b upset=%b",
               req, state_o, upset_o, exp_state, exp_upset);
    end
  endtask

  // drive at negedge, clock one edge, check at the following negedge
  task automatic step(input logic ld, input logic [N-1:0] nx,
                      input logic [IW-1:0] inj, input string req);
    load_en = ld; next_i = nx; inj_i = inj;
    @(posedge clk);
    if (ld) exp_state = nx;
    exp_upset = (inj != '0);
    @(negedge clk);
    chk(req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(20240517));
    @(negedge clk);
    @(negedge clk);
    exp_state = oh(RI); exp_upset = 1'b0;
    chk("R1 reset");
    rst = 1'b0;

    step(1'b1, oh(3), '0, "R2 load");
    step(1'b0, oh(5), '0, "R3 hold");

    // R4: each one-hot bit, enable low
    for (int i = 0; i < N; i++) begin
      step(1'b0, '0, flip(i), "R4 onehot flip");
      step(1'b0, '0, '0, "R4 repaired");
    end
    // R5: each index bit and the parity bit
    for (int b = 0; b < BW + 1; b++) begin
      step(1'b0, '0, flip(N + b), "R5 shadow flip");
      step(1'b0, '0, '0, "R5 repaired");
    end
    // R2 under a flip on the load edge
    step(1'b1, oh(1), flip(1), "R2 load with onehot flip");
    step(1'b1, oh(4), flip(N), "R2 load with index flip");
    step(1'b1, oh(2), flip(IW - 1), "R2 load with parity flip");
    // R7: back-to-back flips in different copies with enable low
    step(1'b0, '0, flip(2), "R7 first flip onehot");
    step(1'b0, '0, flip(N + 1), "R7 second flip index");
    step(1'b0, '0, flip(IW - 1), "R7 third flip parity");
    step(1'b0, '0, flip(0), "R7 fourth flip onehot");
    step(1'b0, '0, '0, "R6 flag clears");

    // reset mid-run
    rst = 1'b1;
    @(posedge clk);
    exp_state = oh(RI); exp_upset = 1'b0;
    @(negedge clk);
    chk("R1 reset again");
    rst = 1'b0;

    for (int c = 0; c < 400; c++) begin
      logic          ld;
      logic [IW-1:0] m;
      ld = ($urandom % 2) == 1;
      m  = (($urandom % 3) == 0) ? flip($urandom % IW) : '0;
      step(ld, oh($urandom % N), m, "R2 R3 R6 R8 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule